// File: doc/BRIEF.md
# Interrupt Status Unit with Held Completion

This block keeps the interrupt code, status and sequence-step registers of a SCSI-style bus controller and drives one level-sensitive interrupt line to the host. The controller core reports what happened through single-cycle event strobes: function complete, bus service, disconnect, bus reset, and command complete with its status byte. Software sees the result through a byte-wide register read port. A small write port holds the transfer-count bytes and configuration register 1.

Reading the interrupt register hands back its current value and acknowledges the interrupt. The clear takes effect on the following clock edge. A command completion that shows up while an interrupt is still unacknowledged is not reported at once. The block keeps its status byte aside and reports it during the read that acknowledges the earlier interrupt, so software never loses an event. A soft reset strobe returns every register to its reset state, the same as the hard reset. All ports are plain register and strobe pins. The block has no streaming data path, so it has no valid/ready handshake and applies no back-pressure.

Top module: `scsi_irq_status`

## Requirements
- R1: After reset, irq_o is low. Status (address 4), interrupt code (address 5), sequence step (address 6), held status byte (address 9) and the transfer-count bytes (addresses 0 to 2) all read 0x00. Configuration register 1 (address 8) reads 0x07.
- R2: A function-complete, bus-service or disconnect strobe ORs its code into the interrupt register: 0x08, 0x10 and 0x20 respectively. On the next edge it also sets status bit 7 and asserts irq_o. If the interrupt is already pending, it stays asserted.
- R3: A read of address 5 returns the value held before the read. After the edge, the interrupt register is 0x00, status bit 7 and status bit 4 (terminal count) are clear, the sequence step is 4 and irq_o is low, unless a new raise occurs.
- R4: A command-complete strobe with no interrupt pending takes effect on the next edge. Status becomes 0x93 (interrupt bit 7, terminal count bit 4, status-phase code 3 in bits 2:0). The interrupt register becomes 0x10 and the sequence step 0. The transfer-count bytes become 0, address 9 holds the strobe's status byte, and irq_o is high.
- R5: A command-complete strobe while irq_o is high changes none of the status, interrupt-code and held-status registers. Its status byte is kept in a hidden slot.
- R6: The address-5 read that acknowledges the pending interrupt reports a kept completion exactly as in R4, using the kept status byte. irq_o stays high. A second read then finds nothing kept.
- R7: A bus-reset strobe ORs 0x80 into the interrupt register. It raises the interrupt only when bit 6 of configuration register 1 is 0.
- R8: A soft_rst pulse restores every register to its R1 value, drops any kept completion and deasserts irq_o.
- R9: When an address-5 read and a raise strobe fall in the same cycle, the read returns the old value. The clear applies first, then the raise, so the interrupt register then holds only the new code and irq_o stays high.
- R10: Writes to addresses 0 to 2 load the transfer-count bytes and clear status bit 4. A write to address 8 loads configuration register 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset strobe |
| ev_func_done | input | 1 | Function-complete event strobe |
| ev_bus_svc | input | 1 | Bus-service event strobe |
| ev_disc | input | 1 | Disconnect event strobe |
| ev_bus_reset | input | 1 | Bus-reset event strobe |
| ev_cmd_done | input | 1 | Command-complete event strobe |
| cmd_status | input | 8 | Status byte accompanying ev_cmd_done |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe; a read of address 5 acknowledges |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data, combinational from current state |
| irq_o | output | 1 | Level interrupt to host |

## Verification
The hardest situation to reach is a held completion. The slot fills only when a completion arrives while another interrupt is unacknowledged, and it empties only inside an acknowledging read. The stimulus first raises a disconnect, then strobes a completion and checks that every visible register is untouched. It then reads the interrupt code and checks that the kept status byte appears with irq_o still high. A separate sequence fills the slot and then issues a soft reset, to show that the kept completion is dropped.

// File: rtl/sis_pkg.sv
package sis_pkg;
  localparam int AW = 4;
  localparam int DW = 8;

  localparam logic [AW-1:0] A_STAT = 4'h4;
  localparam logic [AW-1:0] A_INTR = 4'h5;
  localparam logic [AW-1:0] A_SEQ  = 4'h6;
  localparam logic [AW-1:0] A_CFG1 = 4'h8;
  localparam logic [AW-1:0] A_LAST = 4'h9;

  localparam logic [DW-1:0] IC_FUNC = 8'h08;
  localparam logic [DW-1:0] IC_SVC  = 8'h10;
  localparam logic [DW-1:0] IC_DISC = 8'h20;
  localparam logic [DW-1:0] IC_BRST = 8'h80;

  localparam int            ST_TC_BIT   = 4;
  localparam logic [2:0]    PH_STATUS   = 3'd3;
  localparam logic [2:0]    SEQ_DONE    = 3'd4;
  localparam int            RPT_OFF_BIT = 6;
endpackage

// File: rtl/sis_irq_line.sv
module sis_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic raise,
  input  logic lower,
  output logic level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level <= 1'b0;
    else if (soft_rst) level <= 1'b0;
    else if (raise)    level <= 1'b1;   // raise is applied after the lower
    else if (lower)    level <= 1'b0;
  end
endmodule

// File: rtl/sis_defer_slot.sv
module sis_defer_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          capture,
  input  logic [DW-1:0] cap_status,
  input  logic          release_i,
  output logic          pending,
  output logic [DW-1:0] held_status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending     <= 1'b0;
      held_status <= '0;
    end else if (soft_rst) begin
      pending     <= 1'b0;
      held_status <= '0;
    end else if (capture) begin
      pending     <= 1'b1;
      held_status <= cap_status;
    end else if (release_i) begin
      pending     <= 1'b0;
    end
  end
endmodule

// File: rtl/sis_cfg_regs.sv
module sis_cfg_regs import sis_pkg::*; #(
  parameter int            TC_BYTES = 3,
  parameter logic [DW-1:0] CFG1_RST = 8'h07
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         soft_rst,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [DW-1:0]                wr_data,
  input  logic                         zero_tc,
  output logic [TC_BYTES-1:0][DW-1:0]  tc_q,
  output logic [DW-1:0]                cfg1_q,
  output logic                         tc_wr_hit
);
  logic [TC_BYTES-1:0] hit;

  for (genvar g = 0; g < TC_BYTES; g++) begin : g_tc
    assign hit[g] = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tc_q[g] <= '0;
      else if (soft_rst) tc_q[g] <= '0;
      else if (zero_tc)  tc_q[g] <= '0;
      else if (hit[g])   tc_q[g] <= wr_data;
    end
  end

  assign tc_wr_hit = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cfg1_q <= CFG1_RST;
    else if (soft_rst)                     cfg1_q <= CFG1_RST;
    else if (wr_en && wr_addr == A_CFG1)   cfg1_q <= wr_data;
  end
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status import sis_pkg::*; #(
  parameter int            TC_BYTES = 3,
  parameter logic [DW-1:0] CFG1_RST = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          ev_func_done,
  input  logic          ev_bus_svc,
  input  logic          ev_disc,
  input  logic          ev_bus_reset,
  input  logic          ev_cmd_done,
  input  logic [DW-1:0] cmd_status,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq_o
);
  logic                        irq_q;
  logic [6:0]                  stat_q, stat_d;
  logic [DW-1:0]               intr_q, intr_d, last_q, last_d;
  logic [2:0]                  seq_q, seq_d;
  logic                        defer_pending;
  logic [DW-1:0]               defer_status;
  logic [TC_BYTES-1:0][DW-1:0] tc_q;
  logic [DW-1:0]               cfg1_q;
  logic                        tc_wr_hit;

  logic          rd_intr, int_after_rd, report_held, int_mid;
  logic          report_new, report_any, capture, raise_evt, raise_any;
  logic [DW-1:0] evt_bits;

  // ordering: acknowledge first, then held report, then new events
  assign rd_intr      = rd_en && (rd_addr == A_INTR);
  assign int_after_rd = irq_q && !rd_intr;
  assign report_held  = rd_intr && defer_pending;
  assign int_mid      = int_after_rd || report_held;
  assign report_new   = ev_cmd_done && !int_mid;
  assign capture      = ev_cmd_done && int_mid;
  assign report_any   = report_held || report_new;

  assign evt_bits  = (ev_func_done ? IC_FUNC : '0) | (ev_bus_svc   ? IC_SVC  : '0) |
                     (ev_disc      ? IC_DISC : '0) | (ev_bus_reset ? IC_BRST : '0);
  assign raise_evt = ev_func_done || ev_bus_svc || ev_disc ||
                     (ev_bus_reset && !cfg1_q[RPT_OFF_BIT]);
  assign raise_any = raise_evt || report_any;

  sis_irq_line u_line (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .raise(raise_any), .lower(rd_intr), .level(irq_q)
  );

  sis_defer_slot #(.DW(DW)) u_slot (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .capture(capture), .cap_status(cmd_status), .release_i(report_held),
    .pending(defer_pending), .held_status(defer_status)
  );

  sis_cfg_regs #(.TC_BYTES(TC_BYTES), .CFG1_RST(CFG1_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .zero_tc(report_any), .tc_q(tc_q), .cfg1_q(cfg1_q), .tc_wr_hit(tc_wr_hit)
  );

  always_comb begin
    stat_d = stat_q;
    intr_d = intr_q;
    seq_d  = seq_q;
    last_d = last_q;
    if (tc_wr_hit) stat_d[ST_TC_BIT] = 1'b0;
    if (rd_intr) begin
      stat_d[ST_TC_BIT] = 1'b0;
      intr_d            = '0;
      seq_d             = SEQ_DONE;
    end
    if (report_any) begin
      stat_d            = {3'b000, 1'b1, 1'b0, PH_STATUS};
      intr_d            = IC_SVC;
      seq_d             = '0;
      last_d            = report_held ? defer_status : cmd_status;
    end
    intr_d = intr_d | evt_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      stat_q <= '0;
      intr_q <= '0;
      seq_q  <= '0;
      last_q <= '0;
    end else begin
      stat_q <= stat_d;
      intr_q <= intr_d;
      seq_q  <= seq_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < TC_BYTES; i++)
      if (rd_addr == AW'(i)) rd_data = tc_q[i];
    case (rd_addr)
      A_STAT:  rd_data = {irq_q, stat_q};
      A_INTR:  rd_data = intr_q;
      A_SEQ:   rd_data = {5'b00000, seq_q};
      A_CFG1:  rd_data = cfg1_q;
      A_LAST:  rd_data = last_q;
      default: ;
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/sis_chk.sv
module sis_chk import sis_pkg::*; #(
  parameter int TCW = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           soft_rst,
  input logic           ev_func_done,
  input logic           ev_bus_svc,
  input logic           ev_disc,
  input logic           ev_bus_reset,
  input logic           ev_cmd_done,
  input logic           rd_en,
  input logic [AW-1:0]  rd_addr,
  input logic           irq_o,
  input logic           defer_pending,
  input logic [DW-1:0]  cfg1_q,
  input logic [TCW-1:0] tc_flat
);
  logic ack, any_raise;
  assign ack       = rd_en && (rd_addr == A_INTR);
  assign any_raise = ev_func_done || ev_bus_svc || ev_disc;

  p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_raise && !soft_rst) |=> irq_o);

  p_ack_lowers_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !defer_pending && !any_raise && !ev_bus_reset && !ev_cmd_done && !soft_rst) |=> !irq_o);

  p_report_zero_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_done && !irq_o && !soft_rst) |=> (irq_o && tc_flat == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_done && irq_o && !ack && !soft_rst) |=> defer_pending);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && defer_pending && !ev_cmd_done && !soft_rst) |=> (irq_o && !defer_pending));

  p_brst_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bus_reset && cfg1_q[RPT_OFF_BIT] && !irq_o && !any_raise && !ev_cmd_done && !soft_rst)
      |=> !irq_o);

  p_soft_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!irq_o && !defer_pending));
endmodule

bind scsi_irq_status sis_chk #(.TCW(TC_BYTES*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .ev_func_done(ev_func_done), .ev_bus_svc(ev_bus_svc), .ev_disc(ev_disc),
  .ev_bus_reset(ev_bus_reset), .ev_cmd_done(ev_cmd_done),
  .rd_en(rd_en), .rd_addr(rd_addr), .irq_o(irq_o),
  .defer_pending(defer_pending), .cfg1_q(cfg1_q), .tc_flat(tc_q)
);

// File: tb/scsi_irq_status_tb_top.sv
`timescale 1ns/1ps
module scsi_irq_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic ev_func_done = 1'b0, ev_bus_svc = 1'b0, ev_disc = 1'b0;
  logic ev_bus_reset = 1'b0, ev_cmd_done = 1'b0;
  logic [7:0] cmd_status = 8'h00;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic rd_en = 1'b0;
  logic [3:0] rd_addr = 4'h0;
  logic [7:0] rd_data;
  logic irq_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  scsi_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .ev_func_done(ev_func_done), .ev_bus_svc(ev_bus_svc), .ev_disc(ev_disc),
    .ev_bus_reset(ev_bus_reset), .ev_cmd_done(ev_cmd_done), .cmd_status(cmd_status),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    rd_en = 1'b0; rd_addr = a; #0.5; v = rd_data;
  endtask

  task automatic peek_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    peek(a, v); chk(tag, v, exp);
  endtask

  task automatic rd_ack(output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; rd_addr = 4'h5; #0.5; v = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int which, input logic [7:0] st);
    @(negedge clk);
    case (which)
      0: ev_func_done = 1'b1;
      1: ev_bus_svc   = 1'b1;
      2: ev_disc      = 1'b1;
      3: ev_bus_reset = 1'b1;
      default: begin ev_cmd_done = 1'b1; cmd_status = st; end
    endcase
    @(negedge clk);
    ev_func_done = 0; ev_bus_svc = 0; ev_disc = 0; ev_bus_reset = 0; ev_cmd_done = 0;
  endtask

  task automatic t_reset();
    peek_chk("R1 status", 4'h4, 8'h00);
    peek_chk("R1 intr",   4'h5, 8'h00);
    peek_chk("R1 seq",    4'h6, 8'h00);
    peek_chk("R1 cfg1",   4'h8, 8'h07);
    peek_chk("R1 tc0",    4'h0, 8'h00);
    peek_chk("R1 last",   4'h9, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_raise();
    pulse(0, 0);
    chk("R2 irq after func", {7'd0, irq_o}, 8'h01);
    peek_chk("R2 status", 4'h4, 8'h80);
    peek_chk("R2 intr func", 4'h5, 8'h08);
    pulse(1, 0);
    peek_chk("R2 intr accum", 4'h5, 8'h18);
    chk("R2 irq held", {7'd0, irq_o}, 8'h01);
  endtask

  task automatic t_read_clear();
    logic [7:0] v;
    rd_ack(v);
    chk("R3 read returns old", v, 8'h18);
    peek_chk("R3 intr cleared", 4'h5, 8'h00);
    peek_chk("R3 seq done", 4'h6, 8'h04);
    peek_chk("R3 status", 4'h4, 8'h00);
    chk("R3 irq low", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_write();
    wr(4'h0, 8'h12); wr(4'h1, 8'h34); wr(4'h2, 8'h56);
    peek_chk("R10 tc0", 4'h0, 8'h12);
    peek_chk("R10 tc1", 4'h1, 8'h34);
    peek_chk("R10 tc2", 4'h2, 8'h56);
  endtask

  task automatic t_complete();
    logic [7:0] v;
    pulse(4, 8'h02);
    peek_chk("R4 status", 4'h4, 8'h93);
    peek_chk("R4 intr", 4'h5, 8'h10);
    peek_chk("R4 seq", 4'h6, 8'h00);
    peek_chk("R4 tc0", 4'h0, 8'h00);
    peek_chk("R4 tc2", 4'h2, 8'h00);
    peek_chk("R4 last", 4'h9, 8'h02);
    chk("R4 irq", {7'd0, irq_o}, 8'h01);
    rd_ack(v);
    chk("R3 read after completion", v, 8'h10);
    peek_chk("R3 terminal count cleared", 4'h4, 8'h03);
    // R10: tc write clears terminal count
    pulse(4, 8'h01);
    rd_ack(v);
    pulse(4, 8'h01);
    wr(4'h1, 8'hAA);
    peek_chk("R10 tc write clears bit4", 4'h4, 8'h83);
    rd_ack(v);
  endtask

  task automatic t_defer();
    logic [7:0] v;
    pulse(2, 0);
    peek_chk("R5 intr disc", 4'h5, 8'h20);
    pulse(4, 8'h55);
    peek_chk("R5 intr unchanged", 4'h5, 8'h20);
    peek_chk("R5 status unchanged", 4'h4, 8'h83);
    peek_chk("R5 last unchanged", 4'h9, 8'h01);
    rd_ack(v);
    chk("R6 read returns disc", v, 8'h20);
    peek_chk("R6 status", 4'h4, 8'h93);
    peek_chk("R6 intr", 4'h5, 8'h10);
    peek_chk("R6 seq", 4'h6, 8'h00);
    peek_chk("R6 last", 4'h9, 8'h55);
    chk("R6 irq stays high", {7'd0, irq_o}, 8'h01);
    rd_ack(v);
    chk("R6 second read", v, 8'h10);
    chk("R6 nothing held", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_bus_reset();
    logic [7:0] v;
    wr(4'h8, 8'h47);
    pulse(3, 0);
    peek_chk("R7 intr code masked", 4'h5, 8'h80);
    chk("R7 no irq when masked", {7'd0, irq_o}, 8'h00);
    rd_ack(v);
    wr(4'h8, 8'h07);
    peek_chk("R10 cfg1", 4'h8, 8'h07);
    pulse(3, 0);
    chk("R7 irq when enabled", {7'd0, irq_o}, 8'h01);
    peek_chk("R7 intr code", 4'h5, 8'h80);
    rd_ack(v);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    pulse(0, 0);
    @(negedge clk); rd_en = 1'b1; rd_addr = 4'h5; ev_bus_svc = 1'b1; #0.5; v = rd_data;
    @(negedge clk); rd_en = 1'b0; ev_bus_svc = 1'b0;
    chk("R9 read returns old", v, 8'h08);
    peek_chk("R9 intr new only", 4'h5, 8'h10);
    peek_chk("R9 seq done", 4'h6, 8'h04);
    chk("R9 irq high", {7'd0, irq_o}, 8'h01);
    rd_ack(v);
  endtask

  task automatic t_soft();
    logic [7:0] v;
    wr(4'h0, 8'h77); wr(4'h8, 8'h40);
    pulse(0, 0);
    pulse(4, 8'h66);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk("R8 irq low", {7'd0, irq_o}, 8'h00);
    peek_chk("R8 status", 4'h4, 8'h00);
    peek_chk("R8 intr", 4'h5, 8'h00);
    peek_chk("R8 tc0", 4'h0, 8'h00);
    peek_chk("R8 cfg1", 4'h8, 8'h07);
    peek_chk("R8 last", 4'h9, 8'h00);
    rd_ack(v);
    chk("R8 read after soft", v, 8'h00);
    chk("R8 held completion dropped", {7'd0, irq_o}, 8'h00);
    peek_chk("R8 last still zero", 4'h9, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raise();
    t_read_clear();
    t_write();
    t_complete();
    t_defer();
    t_bus_reset();
    t_same_cycle();
    t_soft();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule